// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block gathers the interrupt causes of a graphics-style engine and presents them to software through a small register port. There are three causes. Two are completion events, the end of a binning flush and the end of a rendered frame, that arrive as single-cycle pulses. The third is an out-of-memory condition from the binner, which arrives as a level. Each cause has a status bit that software acknowledges by writing a 1 to it. A completion event stays recorded until it is acknowledged. The out-of-memory bit cannot be acknowledged away while its condition input is still high.

Enabling is split into two write ports. A 1 written to the set port turns a cause on. A 1 written to the clear port turns it off. Zero bits have no effect on either port, so software never needs a read-modify-write to change one enable. Both ports read back the same enable mask. Each status bit is held by a small two-state machine, SRC_IDLE and SRC_PENDING. The EV_SET transition goes from SRC_IDLE to SRC_PENDING when the source asserts. The EV_ACK transition goes from SRC_PENDING back to SRC_IDLE on an acknowledge write, and is taken only if the source is not asserting in that same cycle. A single active-high interrupt line is driven from a register that holds the OR of the pending and enabled causes.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After reset, all status bits are 0, all enables are 0, `irq_o` is 0 and `rd_data` is 0.
- R2: A read at offset 0x0 returns the status word: bit 0 flush done, bit 1 frame done, bit 2 out-of-memory, and all higher bits 0. A pulse on an event input at clock edge N makes its status bit readable from edge N onward.
- R3: A write at offset 0x0 clears every status bit that has a 1 in the write data. Bits written as 0 keep their value.
- R4: If an event pulse arrives in the same cycle as an acknowledge of its bit, the bit stays set.
- R5: While `oom_level_i` is high, status bit 2 is set and an acknowledge write does not clear it. Once the level is low, an acknowledge write clears it.
- R6: A write at offset 0x4 sets the enable of every cause with a 1 in bits 2:0 of the write data. Zero bits leave their enable unchanged.
- R7: A write at offset 0x8 clears the enable of every cause with a 1 in bits 2:0 of the write data. Zero bits leave their enable unchanged.
- R8: A read at offset 0x4 or at offset 0x8 returns the enable mask in bits 2:0, with all higher bits 0.
- R9: Status bits record events whatever the enable mask is. The enable mask gates only the interrupt line.
- R10: `irq_o` at edge N+1 equals the OR, over the three causes, of status AND enable as held after edge N.
- R11: `rd_data` is the value read by a request sampled at the previous edge. It is 0 when there was no read, and 0 for any offset other than 0x0, 0x4 or 0x8. Writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (4) | Byte offset of the register |
| wr_data_i | input | DATA_W (32) | Write data |
| rd_data_o | output | DATA_W (32) | Read data, one cycle after the read strobe |
| flush_done_i | input | 1 | Single-cycle pulse: binning flush finished |
| frame_done_i | input | 1 | Single-cycle pulse: frame render finished |
| oom_level_i | input | 1 | Level: binner out of memory |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
Long runs of random traffic mix event pulses, toggling of the out-of-memory level, writes to all four offsets and reads, against a cycle model held in the bench. These runs catch wrong masking, wrong interrupt timing and wrong read-back. Directed cases then isolate the points the random traffic hides. A status bit is set while its cause is disabled, which separates recording from gating. Zero-valued writes to the set and clear ports show that they are true no-ops. A pulse that coincides with an acknowledge separates set-wins priority from clear-wins priority. An acknowledge while the out-of-memory level is still high separates held-level behaviour from a plain sticky bit.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;

    localparam int NUM_SRC = 3;

    // Status bit positions, seen by software
    localparam int SRC_FLUSH = 0;
    localparam int SRC_FRAME = 1;
    localparam int SRC_OOM   = 2;

    // Register byte offsets
    localparam int OFF_STATUS = 'h0;
    localparam int OFF_EN_SET = 'h4;
    localparam int OFF_EN_CLR = 'h8;

    typedef enum logic {
        SRC_IDLE    = 1'b0,
        SRC_PENDING = 1'b1
    } src_state_e;

endpackage

// File: rtl/irq_src_fsm.sv
module irq_src_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic pend_o
);
    import gfx_irq_pkg::*;

    src_state_e state_q;
    src_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // EV_SET: IDLE -> PENDING; EV_ACK: PENDING -> IDLE unless set in same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE:    if (set_i)           state_d = SRC_PENDING;
            SRC_PENDING: if (ack_i && !set_i) state_d = SRC_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == SRC_PENDING);
    end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] en_o
);
    logic [N-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (set_we_i) begin
            en_q <= en_q | mask_i;
        end else if (clr_we_i) begin
            en_q <= en_q & ~mask_i;
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
    parameter int N      = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      status_i,
    input  logic [N-1:0]      en_i,
    output logic [DATA_W-1:0] value_o
);
    import gfx_irq_pkg::*;

    always_comb begin
        value_o = '0;
        if (addr_i == ADDR_W'(OFF_STATUS)) begin
            value_o[N-1:0] = status_i;
        end else if (addr_i == ADDR_W'(OFF_EN_SET) || addr_i == ADDR_W'(OFF_EN_CLR)) begin
            value_o[N-1:0] = en_i;
        end
    end

endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              flush_done_i,
    input  logic              frame_done_i,
    input  logic              oom_level_i,
    output logic              irq_o
);
    import gfx_irq_pkg::*;

    localparam int N = NUM_SRC;

    logic [N-1:0]      src_set;
    logic [N-1:0]      status_vec;
    logic [N-1:0]      enable_vec;
    logic [N-1:0]      wmask;
    logic              wr_status;
    logic              wr_en_set;
    logic              wr_en_clr;
    logic [DATA_W-1:0] rd_value;
    logic [DATA_W-1:0] rd_data_q;
    logic              irq_q;

    assign wmask     = wr_data_i[N-1:0];
    assign wr_status = wr_en_i && (addr_i == ADDR_W'(OFF_STATUS));
    assign wr_en_set = wr_en_i && (addr_i == ADDR_W'(OFF_EN_SET));
    assign wr_en_clr = wr_en_i && (addr_i == ADDR_W'(OFF_EN_CLR));

    always_comb begin
        src_set            = '0;
        src_set[SRC_FLUSH] = flush_done_i;
        src_set[SRC_FRAME] = frame_done_i;
        src_set[SRC_OOM]   = oom_level_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_src
        irq_src_fsm u_src (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (src_set[g]),
            .ack_i  (wr_status && wmask[g]),
            .pend_o (status_vec[g])
        );
    end

    irq_enable_reg #(.N(N)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we_i (wr_en_set),
        .clr_we_i (wr_en_clr),
        .mask_i   (wmask),
        .en_o     (enable_vec)
    );

    irq_read_mux #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
        .addr_i   (addr_i),
        .status_i (status_vec),
        .en_i     (enable_vec),
        .value_o  (rd_value)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
            irq_q     <= 1'b0;
        end else begin
            rd_data_q <= rd_en_i ? rd_value : '0;
            irq_q     <= |(status_vec & enable_vec);
        end
    end

    assign rd_data_o = rd_data_q;
    assign irq_o     = irq_q;

endmodule

// File: rtl/gfx_irq_ctrl_chk.sv
module gfx_irq_ctrl_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int N      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              flush_done_i,
    input logic              frame_done_i,
    input logic              oom_level_i,
    input logic              irq_o,
    input logic [N-1:0]      status_vec,
    input logic [N-1:0]      enable_vec
);
    import gfx_irq_pkg::*;

    AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_vec & enable_vec) != '0) |=> irq_o); // R10
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_vec & enable_vec) == '0) |=> !irq_o); // R10
    AST_FLUSH_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done_i |=> status_vec[SRC_FLUSH]); // R4
    AST_FRAME_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_i |=> status_vec[SRC_FRAME]); // R4
    AST_OOM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        oom_level_i |=> status_vec[SRC_OOM]); // R5
    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(OFF_EN_SET))
        |=> ((enable_vec & $past(wr_data_i[N-1:0])) == $past(wr_data_i[N-1:0]))); // R6
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(OFF_EN_CLR))
        |=> ((enable_vec & $past(wr_data_i[N-1:0])) == '0)); // R7
    AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !flush_done_i && !frame_done_i && !oom_level_i)
        |=> $stable(status_vec)); // R3
    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rd_data_o == '0)); // R11
    AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[DATA_W-1:N] == '0); // R2

endmodule

bind gfx_irq_ctrl gfx_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .addr_i       (addr_i),
    .wr_data_i    (wr_data_i),
    .rd_data_o    (rd_data_o),
    .flush_done_i (flush_done_i),
    .frame_done_i (frame_done_i),
    .oom_level_i  (oom_level_i),
    .irq_o        (irq_o),
    .status_vec   (status_vec),
    .enable_vec   (enable_vec)
);

// File: tb/gfx_irq_ctrl_bench.sv
module gfx_irq_ctrl_bench;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          flush = 1'b0;
    logic          frame = 1'b0;
    logic          oom = 1'b0;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    // Bench model state
    logic [2:0]    m_status = '0;
    logic [2:0]    m_en = '0;
    logic          m_irq = 1'b0;
    logic [DW-1:0] m_rdata = '0;

    always #4 clk = ~clk;

    gfx_irq_ctrl u_gfx_irq_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .rd_en_i      (rd_en),
        .addr_i       (addr),
        .wr_data_i    (wdata),
        .rd_data_o    (rdata),
        .flush_done_i (flush),
        .frame_done_i (frame),
        .oom_level_i  (oom),
        .irq_o        (irq)
    );

    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a,
                                                 input logic [2:0] st,
                                                 input logic [2:0] en);
        logic [DW-1:0] v = '0;
        if (a == 4'h0) v[2:0] = st;
        else if (a == 4'h4 || a == 4'h8) v[2:0] = en;
        return v;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: advance model with current inputs, compare at negedge
    task automatic cycle();
        logic [2:0] clr = (wr_en && addr == 4'h0) ? wdata[2:0] : 3'b0;
        logic [2:0] set = {oom, frame, flush};
        logic [2:0] ens = (wr_en && addr == 4'h4) ? wdata[2:0] : 3'b0;
        logic [2:0] enc = (wr_en && addr == 4'h8) ? wdata[2:0] : 3'b0;
        logic [DW-1:0] rd_n = rd_en ? model_read(addr, m_status, m_en) : '0;
        logic irq_n = |(m_status & m_en);
        @(posedge clk);
        m_status = (m_status & ~clr) | set;
        m_en     = (m_en | ens) & ~enc;
        m_rdata  = rd_n;
        m_irq    = irq_n;
        @(negedge clk);
        check("R10 irq", {31'b0, irq}, {31'b0, m_irq});
        check("R2 R8 R11 rdata", rdata, m_rdata);
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; flush = 0; frame = 0; wdata = '0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle(); wr_en = 1; addr = a; wdata = d;
        cycle(); idle();
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        idle(); rd_en = 1; addr = a;
        cycle();
        check(tag, rdata, exp);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 irq at reset", {31'b0, irq}, '0);
        check("R1 rdata at reset", rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(4'h0, 32'h0, "R1 status after reset");
        do_read(4'h4, 32'h0, "R1 enables after reset");

        // R2 R9: flush recorded while disabled, no irq
        flush = 1; cycle(); idle();
        do_read(4'h0, 32'h1, "R2 R9 flush recorded");
        check("R9 irq stays low", {31'b0, irq}, '0);
        frame = 1; cycle(); idle();
        do_read(4'h0, 32'h3, "R2 frame bit 1");

        // R3: zero write keeps, one write clears
        do_write(4'h0, 32'h0);
        do_read(4'h0, 32'h3, "R3 zero write no effect");
        do_write(4'h0, 32'h1);
        do_read(4'h0, 32'h2, "R3 clear bit 0 only");

        // R4: pulse coinciding with acknowledge
        wr_en = 1; addr = 4'h0; wdata = 32'h2; frame = 1; cycle(); idle();
        do_read(4'h0, 32'h2, "R4 set wins over clear");
        do_write(4'h0, 32'h2);
        do_read(4'h0, 32'h0, "R3 frame cleared");

        // R5: held out-of-memory level
        oom = 1; cycle();
        do_write(4'h0, 32'h4);
        do_read(4'h0, 32'h4, "R5 oom held while level high");
        oom = 0; cycle();
        do_read(4'h0, 32'h4, "R5 oom sticky after level drops");
        do_write(4'h0, 32'h4);
        do_read(4'h0, 32'h0, "R5 oom cleared once level low");

        // R6 R8: enable set
        do_write(4'h4, 32'h1);
        do_write(4'h4, 32'h0);
        do_read(4'h4, 32'h1, "R6 set port zero bits no effect");
        do_read(4'h8, 32'h1, "R8 clear port reads mask");
        // R10: irq two edges after pulse
        flush = 1; cycle(); idle();
        check("R10 irq not yet", {31'b0, irq}, '0);
        cycle();
        check("R10 irq raised", {31'b0, irq}, 32'h1);
        // R7: clear port
        do_write(4'h4, 32'h6);
        do_write(4'h8, 32'h0);
        do_read(4'h4, 32'h7, "R7 clear port zero bits no effect");
        do_write(4'h8, 32'h5);
        do_read(4'h8, 32'h2, "R7 clear port disables");
        cycle();
        check("R10 irq dropped", {31'b0, irq}, '0);

        // R11: unmapped offset
        do_write(4'hC, 32'h7);
        do_read(4'hC, 32'h0, "R11 unmapped reads zero");
        do_read(4'h4, 32'h2, "R11 unmapped write ignored");
        do_read(4'h0, 32'h1, "R11 status untouched");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int op = $urandom_range(0, 3);
            idle();
            flush = ($urandom_range(0, 7) == 0);
            frame = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 15) == 0) oom = ~oom;
            rd_en = $urandom_range(0, 1);
            wr_en = $urandom_range(0, 2) == 0;
            addr  = 4'(op * 4);
            wdata = ($urandom_range(0, 3) == 0) ? $urandom() : {29'b0, 3'($urandom_range(0, 7))};
            cycle();
        end
        idle();
        cycle();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule